// File: doc/BRIEF.md
# Frame Buffer Fetch Setup Sequencer

This block prepares every display frame before a pixel fetch engine starts moving data. When software turns the controller on, it validates the frame buffer boundary addresses against the memory system. Unless the load mode skips the palette, it then reads the palette header once. On each start-of-frame strobe it reads the first 16-bit word of the current frame buffer and decodes the colour depth and the header length from that word. It then checks that the programmed panel fits inside the buffer. On success it hands the fetch engine a pixel start address, a depth, a colour format and a line window.

The sequencer has two buffers. In dual mode it alternates between them on every good frame. Each good frame raises a per-buffer condition strobe and, if masked in, a DMA interrupt. A bad boundary address or a panel that is too large for its buffer turns the controller off. Software must then lower and raise the enable request to start again. The pixel fetch itself lies outside this block.

Top module: `fbsetup_seq`

## Requirements
- R1: On a rising `en_req`, the block checks the buffer addresses in the order top0, bottom0, top1, bottom1, presenting one per cycle on `chk_addr`. The buffer 1 addresses are checked only when `dual` is 1. The first address with `addr_ok` low raises `addr_err` for one cycle, sets `cond_set` to 3'b100 and pulses `dma_irq` equal to `irq_mask[1]`, and drops `active`.
- R2: After a clean address check, unless `load_mode` is 2, the block reads one word at buffer 0 top and pulses `pal_loaded`. With `load_mode` 2 no read and no `pal_loaded` occur.
- R3: The depth code is bits 14:12 of the fetched word. Codes 1, 2 and 3 give `bpp` 2, 4 and 8, and codes 4 to 7 give 16. Code 0 pulses `frame_skip` and produces no frame.
- R4: `fmt16` is 1 only for a 16 bpp frame with `tft` set. A 16 bpp frame with `tft` clear has `fmt16` 0, which selects the 12-bit format.
- R5: With `load_mode` not 2, the header offset is 0x200 bytes for codes 3 to 7 and 0x20 bytes for codes 1 and 2. With `load_mode` 2 the offset is 0 and the last fetched word is reused without a read. `pix_addr` is the current buffer top plus the offset.
- R6: If offset + width*height*bpp/8 is greater than (bottom - top) + 2 of the current buffer, the block pulses `sync_err` and drops `active`. Equality still passes.
- R7: Each good frame pulses `frame_go` with `cond_set` bit `cur_frame` set alone and `dma_irq` equal to `irq_mask[0]`. In dual mode `cur_frame` then toggles, and enable resets it to 0.
- R8: `line_count` is `height` and `first_line` is 0, unless `subpanel` bit 31 is set. In that case bits 25:16 give `first_line` when bit 29 is 1, and give `line_count` when bit 29 is 0.
- R9: A `sof` strobe has no effect while `load_mode` is 1 or while `active` is 0.
- R10: A `sof` strobe that arrives while a frame setup is in progress is ignored.
- R11: After reset, or one cycle after `en_req` is low, `active` is 0 and `cur_frame` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Controller enable request (level) |
| load_mode | input | 2 | 0: palette and data, 1: no frames, 2: data only |
| tft | input | 1 | Active-matrix panel flag |
| dual | input | 1 | Alternate between two buffers |
| irq_mask | input | 2 | Bit 0 frame interrupt, bit 1 address fault interrupt |
| width | input | DIM_W | Panel width in pixels |
| height | input | DIM_W | Panel height in lines |
| subpanel | input | 32 | Subpanel control word |
| buf0_top | input | AW | Buffer 0 start address |
| buf0_bot | input | AW | Buffer 0 end address |
| buf1_top | input | AW | Buffer 1 start address |
| buf1_bot | input | AW | Buffer 1 end address |
| sof | input | 1 | Start-of-frame strobe |
| chk_addr | output | AW | Address under validity check |
| addr_ok | input | 1 | Validity response for `chk_addr`, same cycle |
| rd_req | output | 1 | Header word read request |
| rd_addr | output | AW | Header word address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Read data |
| active | output | 1 | Controller running |
| cur_frame | output | 1 | Current buffer index |
| frame_go | output | 1 | Frame setup done, outputs valid |
| pix_addr | output | AW | Pixel data start address |
| bpp | output | 5 | Bits per pixel |
| fmt16 | output | 1 | 1: 16-bit format, 0: 12-bit format at 16 bpp |
| first_line | output | DIM_W | First displayed line |
| line_count | output | DIM_W | Displayed line count |
| frame_skip | output | 1 | Unsupported depth, frame dropped |
| sync_err | output | 1 | Panel larger than buffer |
| addr_err | output | 1 | Invalid buffer address |
| pal_loaded | output | 1 | Palette header read done |
| cond_set | output | 3 | DMA condition strobes |
| dma_irq | output | 1 | DMA interrupt strobe |

## Verification
A wrong buffer index shows up on the next `frame_go` as a `pix_addr` that points into the other buffer, and as the wrong `cond_set` bit. A stuck busy state shows up as a missing event after the next `sof`. A bad latched header word shows as a wrong `bpp` or offset within the same frame. A scoreboard tracks its own buffer index and last header word, so any drift is reported at the first frame after it happens.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_PAL,
    ST_RDY,
    ST_FETCH,
    ST_EVAL
  } fbs_state_e;

  // Depth code to bits per pixel; 0 means unsupported.
  function automatic logic [4:0] code_to_bpp(input logic [2:0] code);
    logic [4:0] r;
    case (code)
      3'd0:    r = 5'd0;
      3'd1:    r = 5'd2;
      3'd2:    r = 5'd4;
      3'd3:    r = 5'd8;
      default: r = 5'd16;
    endcase
    return r;
  endfunction

  // Palette header length in bytes ahead of the pixel data.
  function automatic logic [9:0] hdr_bytes(input logic [2:0] code, input logic [1:0] mode);
    logic [9:0] r;
    if (mode == 2'd2)      r = 10'd0;
    else if (code >= 3'd3) r = 10'h200;
    else                   r = 10'h020;
    return r;
  endfunction

  // Bytes the frame occupies, header included, in a wide result.
  function automatic logic [39:0] frame_bytes(input logic [15:0] w, input logic [15:0] h,
                                              input logic [4:0] depth, input logic [9:0] off);
    logic [39:0] prod;
    prod = 40'(w) * 40'(h) * 40'(depth);
    return 40'(off) + (prod >> 3);
  endfunction

endpackage

// File: rtl/fbs_hdr_decode.sv
module fbs_hdr_decode
  import fbs_pkg::*;
(
  input  logic [2:0] code,
  input  logic       tft,
  input  logic [1:0] load_mode,
  output logic [4:0] bpp,
  output logic       fmt16,
  output logic [9:0] off,
  output logic       unsup
);

  always_comb begin
    bpp   = code_to_bpp(code);
    off   = hdr_bytes(code, load_mode);
    unsup = (code == 3'd0);
    fmt16 = tft && (bpp == 5'd16);
  end

  // R3
  always_comb begin
    if (!$isunknown(code) && !unsup) begin
      bpp_pow2_chk: assert ($countones(bpp) == 1)
        else $error("supported depth code gave a bpp that is not a power of two");
    end
  end

endmodule

// File: rtl/fbs_fit_check.sv
module fbs_fit_check
  import fbs_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DIM_W = 11
) (
  input  logic [AW-1:0]    top,
  input  logic [AW-1:0]    bot,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic [4:0]       bpp,
  input  logic [9:0]       off,
  output logic             overrun
);

  localparam int WIDE = 40;

  logic [WIDE-1:0] need;
  logic [WIDE-1:0] room;
  logic [AW-1:0]   span;

  always_comb begin
    span    = bot - top;
    need    = frame_bytes(16'(width), 16'(height), bpp, off);
    room    = WIDE'(span) + WIDE'(2);
    overrun = need > room;
  end

endmodule

// File: rtl/fbs_line_window.sv
module fbs_line_window #(
  parameter int DIM_W = 11
) (
  input  logic [31:0]      subpanel,
  input  logic [DIM_W-1:0] height,
  output logic [DIM_W-1:0] first_line,
  output logic [DIM_W-1:0] line_count
);

  logic       win_on;
  logic       win_is_first;
  logic [9:0] win_field;
  logic       unused_sub;

  assign win_on       = subpanel[31];
  assign win_is_first = subpanel[29];
  assign win_field    = subpanel[25:16];
  assign unused_sub   = ^{subpanel[30], subpanel[28:26], subpanel[15:0]};

  always_comb begin
    first_line = '0;
    line_count = height;
    if (win_on) begin
      if (win_is_first) first_line = DIM_W'(win_field);
      else              line_count = DIM_W'(win_field);
    end
  end

endmodule

// File: rtl/fbsetup_seq.sv
module fbsetup_seq
  import fbs_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DIM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req,
  input  logic [1:0]       load_mode,
  input  logic             tft,
  input  logic             dual,
  input  logic [1:0]       irq_mask,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic [31:0]      subpanel,
  input  logic [AW-1:0]    buf0_top,
  input  logic [AW-1:0]    buf0_bot,
  input  logic [AW-1:0]    buf1_top,
  input  logic [AW-1:0]    buf1_bot,
  input  logic             sof,
  output logic [AW-1:0]    chk_addr,
  input  logic             addr_ok,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_valid,
  input  logic [15:0]      rd_data,
  output logic             active,
  output logic             cur_frame,
  output logic             frame_go,
  output logic [AW-1:0]    pix_addr,
  output logic [4:0]       bpp,
  output logic             fmt16,
  output logic [DIM_W-1:0] first_line,
  output logic [DIM_W-1:0] line_count,
  output logic             frame_skip,
  output logic             sync_err,
  output logic             addr_err,
  output logic             pal_loaded,
  output logic [2:0]       cond_set,
  output logic             dma_irq
);

  localparam logic [1:0] LAST_SINGLE = 2'd1;
  localparam logic [1:0] LAST_DUAL   = 2'd3;

  fbs_state_e state_q;
  logic       en_q;
  logic       act_q;
  logic       cur_q;
  logic [1:0] idx_q;
  logic [2:0] code_q;

  // Named internal events
  logic       en_rise;
  logic       sof_take;
  logic       chk_last;
  logic [1:0] chk_end;
  logic       read_done;

  logic [AW-1:0] cur_top;
  logic [AW-1:0] cur_bot;

  logic [4:0]       dec_bpp;
  logic             dec_fmt16;
  logic [9:0]       dec_off;
  logic             dec_unsup;
  logic             fit_over;
  logic [DIM_W-1:0] win_first;
  logic [DIM_W-1:0] win_count;
  logic             unused_rd;

  logic             go_q, skip_q, sync_q, aerr_q, pal_q, irq_q;
  logic [2:0]       cond_q;
  logic [AW-1:0]    pix_q;
  logic [4:0]       bpp_q;
  logic             fmt_q;
  logic [DIM_W-1:0] first_q, count_q;

  assign unused_rd = ^{rd_data[15], rd_data[11:0]};

  assign en_rise   = en_req && !en_q;
  assign sof_take  = (state_q == ST_RDY) && sof && (load_mode != 2'd1);
  assign chk_end   = dual ? LAST_DUAL : LAST_SINGLE;
  assign chk_last  = (idx_q == chk_end);
  assign read_done = rd_req && rd_valid;

  assign cur_top = cur_q ? buf1_top : buf0_top;
  assign cur_bot = cur_q ? buf1_bot : buf0_bot;

  always_comb begin
    case (idx_q)
      2'd0:    chk_addr = buf0_top;
      2'd1:    chk_addr = buf0_bot;
      2'd2:    chk_addr = buf1_top;
      default: chk_addr = buf1_bot;
    endcase
  end

  assign rd_req  = (state_q == ST_PAL) || (state_q == ST_FETCH);
  assign rd_addr = cur_top;

  fbs_hdr_decode u_dec (
    .code      (code_q),
    .tft       (tft),
    .load_mode (load_mode),
    .bpp       (dec_bpp),
    .fmt16     (dec_fmt16),
    .off       (dec_off),
    .unsup     (dec_unsup)
  );

  fbs_fit_check #(.AW(AW), .DIM_W(DIM_W)) u_fit (
    .top     (cur_top),
    .bot     (cur_bot),
    .width   (width),
    .height  (height),
    .bpp     (dec_bpp),
    .off     (dec_off),
    .overrun (fit_over)
  );

  fbs_line_window #(.DIM_W(DIM_W)) u_win (
    .subpanel   (subpanel),
    .height     (height),
    .first_line (win_first),
    .line_count (win_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      act_q   <= 1'b0;
      cur_q   <= 1'b0;
      idx_q   <= '0;
      code_q  <= '0;
      go_q    <= 1'b0;
      skip_q  <= 1'b0;
      sync_q  <= 1'b0;
      aerr_q  <= 1'b0;
      pal_q   <= 1'b0;
      irq_q   <= 1'b0;
      cond_q  <= '0;
      pix_q   <= '0;
      bpp_q   <= '0;
      fmt_q   <= 1'b0;
      first_q <= '0;
      count_q <= '0;
    end else begin
      en_q   <= en_req;
      go_q   <= 1'b0;
      skip_q <= 1'b0;
      sync_q <= 1'b0;
      aerr_q <= 1'b0;
      pal_q  <= 1'b0;
      irq_q  <= 1'b0;
      cond_q <= '0;
      if (!en_req) begin
        state_q <= ST_IDLE;
        act_q   <= 1'b0;
        cur_q   <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (en_rise) begin
              act_q   <= 1'b1;
              cur_q   <= 1'b0;
              idx_q   <= '0;
              state_q <= ST_CHK;
            end
          end
          ST_CHK: begin
            if (!addr_ok) begin
              aerr_q  <= 1'b1;
              cond_q  <= 3'b100;
              irq_q   <= irq_mask[1];
              act_q   <= 1'b0;
              state_q <= ST_IDLE;
            end else if (chk_last) begin
              state_q <= (load_mode != 2'd2) ? ST_PAL : ST_RDY;
            end else begin
              idx_q <= idx_q + 2'd1;
            end
          end
          ST_PAL: begin
            if (read_done) begin
              code_q  <= rd_data[14:12];
              pal_q   <= 1'b1;
              state_q <= ST_RDY;
            end
          end
          ST_RDY: begin
            if (sof_take) state_q <= (load_mode == 2'd2) ? ST_EVAL : ST_FETCH;
          end
          ST_FETCH: begin
            if (read_done) begin
              code_q  <= rd_data[14:12];
              state_q <= ST_EVAL;
            end
          end
          ST_EVAL: begin
            if (dec_unsup) begin
              skip_q  <= 1'b1;
              state_q <= ST_RDY;
            end else if (fit_over) begin
              sync_q  <= 1'b1;
              act_q   <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              go_q    <= 1'b1;
              pix_q   <= cur_top + AW'(dec_off);
              bpp_q   <= dec_bpp;
              fmt_q   <= dec_fmt16;
              first_q <= win_first;
              count_q <= win_count;
              cond_q  <= cur_q ? 3'b010 : 3'b001;
              irq_q   <= irq_mask[0];
              if (dual) cur_q <= ~cur_q;
              state_q <= ST_RDY;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign active     = act_q;
  assign cur_frame  = cur_q;
  assign frame_go   = go_q;
  assign pix_addr   = pix_q;
  assign bpp        = bpp_q;
  assign fmt16      = fmt_q;
  assign first_line = first_q;
  assign line_count = count_q;
  assign frame_skip = skip_q;
  assign sync_err   = sync_q;
  assign addr_err   = aerr_q;
  assign pal_loaded = pal_q;
  assign cond_set   = cond_q;
  assign dma_irq    = irq_q;

  // R1
  addr_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!active && cond_set == 3'b100))
    else $error("address fault left the controller running");

  // R6
  sync_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> !active)
    else $error("size overrun left the controller running");

  // R7
  frame_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |-> ($countones(cond_set) == 1 && !cond_set[2]))
    else $error("frame done without a single buffer condition");

  // R4
  fmt_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go && fmt16 |-> bpp == 5'd16)
    else $error("16-bit format flagged below 16 bpp");

  // R11
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_req |=> (!active && !cur_frame))
    else $error("controller stayed active after enable dropped");

  // R2
  pal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_loaded |-> (active && !cur_frame))
    else $error("palette load outside an enabled session");

endmodule

// File: tb/fbsetup_seq_bench.sv
`timescale 1ns/1ps
module fbsetup_seq_bench;

  localparam int AW = 32;
  localparam int DIM_W = 11;

  typedef struct {
    int          kind;   // 0 frame, 1 skip, 2 sync, 3 addr, 4 palette
    logic [31:0] addr;
    int          bpp;
    bit          fmt;
    int          first;
    int          count;
    logic [2:0]  cond;
    bit          irq;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             en_req = 0;
  logic [1:0]       load_mode = 0;
  logic             tft = 0, dual = 0;
  logic [1:0]       irq_mask = 0;
  logic [DIM_W-1:0] width = 11'd16, height = 11'd8;
  logic [31:0]      subpanel = 0;
  logic [AW-1:0]    buf0_top = 32'h1000, buf0_bot = 32'h2000;
  logic [AW-1:0]    buf1_top = 32'h4000, buf1_bot = 32'h5000;
  logic             sof = 0;
  logic [AW-1:0]    chk_addr;
  logic             addr_ok;
  logic             rd_req;
  logic [AW-1:0]    rd_addr;
  logic             rd_valid;
  logic [15:0]      rd_data;
  logic             active, cur_frame, frame_go, fmt16;
  logic [AW-1:0]    pix_addr;
  logic [4:0]       bpp;
  logic [DIM_W-1:0] first_line, line_count;
  logic             frame_skip, sync_err, addr_err, pal_loaded, dma_irq;
  logic [2:0]       cond_set;

  logic [AW-1:0] bad_addr = 32'hFFFF_FFFF;
  logic [15:0]   word0 = 0, word1 = 0;
  int            rd_lat = 0;
  int            rd_cnt = 0;

  assign addr_ok  = (chk_addr != bad_addr);
  assign rd_data  = (rd_addr == buf1_top) ? word1 : word0;
  assign rd_valid = rd_req && (rd_cnt >= rd_lat);
  always @(posedge clk) rd_cnt <= rd_req ? rd_cnt + 1 : 0;

  fbsetup_seq #(.AW(AW), .DIM_W(DIM_W)) u_fbsetup_seq (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .load_mode(load_mode), .tft(tft),
    .dual(dual), .irq_mask(irq_mask), .width(width), .height(height),
    .subpanel(subpanel), .buf0_top(buf0_top), .buf0_bot(buf0_bot),
    .buf1_top(buf1_top), .buf1_bot(buf1_bot), .sof(sof), .chk_addr(chk_addr),
    .addr_ok(addr_ok), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .active(active), .cur_frame(cur_frame), .frame_go(frame_go),
    .pix_addr(pix_addr), .bpp(bpp), .fmt16(fmt16), .first_line(first_line),
    .line_count(line_count), .frame_skip(frame_skip), .sync_err(sync_err),
    .addr_err(addr_err), .pal_loaded(pal_loaded), .cond_set(cond_set), .dma_irq(dma_irq)
  );

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  // Scoreboard model state
  bit          m_act = 0;
  bit          m_cur = 0;
  logic [15:0] m_word = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pop and compare on every event pulse
  always @(negedge clk) begin
    if (rst_n && (frame_go || frame_skip || sync_err || addr_err || pal_loaded)) begin
      int k;
      k = frame_go ? 0 : frame_skip ? 1 : sync_err ? 2 : addr_err ? 3 : 4;
      if (q.size() == 0) begin
        check(1'b0, "R10", "unexpected event kind", k, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(k == e.kind, e.req, "event kind", k, e.kind);
        check(cond_set == e.cond, e.req, "cond_set", cond_set, e.cond);
        check(dma_irq == e.irq, e.req, "dma_irq", dma_irq, e.irq);
        if (k == 0 && e.kind == 0) begin
          check(pix_addr == e.addr, e.req, "pix_addr", pix_addr, e.addr);
          check(bpp == e.bpp, e.req, "bpp", bpp, e.bpp);
          check(fmt16 == e.fmt, e.req, "fmt16", fmt16, e.fmt);
          check(first_line == e.first, "R8", "first_line", first_line, e.first);
          check(line_count == e.count, "R8", "line_count", line_count, e.count);
        end
      end
    end
  end

  function automatic int ref_bpp(input logic [2:0] c);
    if (c == 1) return 2;
    if (c == 2) return 4;
    if (c == 3) return 8;
    if (c == 0) return 0;
    return 16;
  endfunction

  task automatic push(input int kind, input logic [31:0] a, input int b, input bit f,
                      input int fl, input int lc, input logic [2:0] c, input bit i,
                      input string req);
    exp_t e;
    e.kind = kind; e.addr = a; e.bpp = b; e.fmt = f; e.first = fl; e.count = lc;
    e.cond = c; e.irq = i; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_enable(input string req);
    bit bad;
    en_req = 0;
    wait_cyc(2);
    bad = (bad_addr == buf0_top) || (bad_addr == buf0_bot) ||
          (dual && ((bad_addr == buf1_top) || (bad_addr == buf1_bot)));
    m_cur = 0;
    if (bad) begin
      push(3, 0, 0, 0, 0, 0, 3'b100, irq_mask[1], "R1");
      m_act = 0;
    end else begin
      m_act = 1;
      if (load_mode != 2) begin
        push(4, 0, 0, 0, 0, 0, 3'b000, 0, req);
        m_word = word0;
      end
    end
    en_req = 1;
    wait_cyc(rd_lat + 14);
  endtask

  task automatic pulse_sof();
    sof = 1;
    wait_cyc(1);
    sof = 0;
  endtask

  task automatic model_frame(input string req);
    logic [15:0] w;
    logic [2:0]  c;
    int b, off, fl, lc;
    longint need, room;
    logic [31:0] top, bot;
    if (!m_act || load_mode == 1) return;
    top = m_cur ? buf1_top : buf0_top;
    bot = m_cur ? buf1_bot : buf0_bot;
    w = (load_mode == 2) ? m_word : (m_cur ? word1 : word0);
    m_word = w;
    c = w[14:12];
    b = ref_bpp(c);
    if (b == 0) begin
      push(1, 0, 0, 0, 0, 0, 3'b000, 0, "R3");
      return;
    end
    off = (load_mode == 2) ? 0 : (c >= 3 ? 512 : 32);
    need = longint'(off) + (longint'(width) * longint'(height) * b) / 8;
    room = longint'(bot - top) + 2;
    if (need > room) begin
      push(2, 0, 0, 0, 0, 0, 3'b000, 0, "R6");
      m_act = 0;
      return;
    end
    fl = 0;
    lc = height;
    if (subpanel[31]) begin
      if (subpanel[29]) fl = subpanel[25:16];
      else              lc = subpanel[25:16];
    end
    push(0, top + off, b, (b == 16) && tft, fl, lc,
         m_cur ? 3'b010 : 3'b001, irq_mask[0], req);
    if (dual) m_cur = ~m_cur;
  endtask

  task automatic do_frame(input string req);
    model_frame(req);
    pulse_sof();
    wait_cyc(rd_lat + 10);
  endtask

  task automatic drain(input string req);
    check(q.size() == 0, req, "pending expected events", q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R11: reset state
    check(active == 0, "R11", "active after reset", active, 0);
    check(cur_frame == 0, "R11", "cur_frame after reset", cur_frame, 0);
    check(frame_go == 0 && cond_set == 0, "R11", "idle outputs", {frame_go, cond_set}, 0);
    rst_n = 1;
    wait_cyc(2);

    // R2, R3, R5: 8 bpp with a 0x200 header, single buffer
    word0 = 16'h3000;
    do_enable("R2");
    check(active == 1, "R1", "active after clean enable", active, 1);
    do_frame("R5");
    do_frame("R7");
    drain("R3");

    // R4: 16 bpp, 12-bit then 16-bit format
    word0 = 16'h5000;
    tft = 0; do_frame("R4");
    tft = 1; do_frame("R4");
    word0 = 16'h7ABC; do_frame("R4");
    // R5: 2 bpp uses a 0x20 header
    word0 = 16'h1000; tft = 0; do_frame("R5");
    // R3: code 0 skips the frame, block stays active
    word0 = 16'h0FFF; do_frame("R3");
    check(active == 1, "R3", "active after skip", active, 1);
    drain("R3");

    // R7: dual alternation with interrupts
    dual = 1; irq_mask = 2'b01;
    word0 = 16'h2000; word1 = 16'h3000;
    do_enable("R2");
    do_frame("R7");
    check(cur_frame == 1, "R7", "cur_frame after first dual frame", cur_frame, 1);
    do_frame("R7");
    do_frame("R7");
    drain("R7");

    // R8: subpanel windows
    dual = 0; irq_mask = 0;
    do_enable("R2");
    subpanel = 32'hA005_0000; do_frame("R8");
    subpanel = 32'h8003_0000; do_frame("R8");
    subpanel = 32'h0007_0000; do_frame("R8");
    subpanel = 0;

    // R6: exact fit passes, one byte less overruns
    word0 = 16'h3000;
    buf0_bot = 32'h127E; do_frame("R6");
    buf0_bot = 32'h127D; do_frame("R6");
    check(active == 0, "R6", "active after overrun", active, 0);
    do_frame("R9");
    drain("R6");
    buf0_bot = 32'h2000;

    // R1: bad buffer 1 address matters only in dual mode
    bad_addr = 32'h5000; irq_mask = 2'b10;
    do_enable("R1");
    check(active == 1, "R1", "single mode ignores buffer 1", active, 1);
    dual = 1;
    do_enable("R1");
    check(active == 0, "R1", "dual mode faults on buffer 1", active, 0);
    drain("R1");
    bad_addr = 32'hFFFF_FFFF; dual = 0; irq_mask = 0;

    // R2, R5: data-only mode, no palette read, zero offset, word reused
    load_mode = 2;
    word0 = 16'h6000;
    do_enable("R2");
    do_frame("R5");
    drain("R2");

    // R9: load mode 1 produces nothing
    load_mode = 1;
    do_frame("R9");
    drain("R9");
    check(active == 1, "R9", "active in mode 1", active, 1);

    // R10: strobe during a slow fetch is ignored
    load_mode = 0; dual = 1; rd_lat = 6;
    word0 = 16'h3000; word1 = 16'h4000;
    do_enable("R2");
    model_frame("R10");
    pulse_sof();
    wait_cyc(2);
    pulse_sof();
    wait_cyc(20);
    check(cur_frame == 1, "R10", "cur_frame after one accepted frame", cur_frame, 1);
    do_frame("R10");
    drain("R10");

    // R11: dropping the enable request
    en_req = 0;
    wait_cyc(1);
    check(active == 0, "R11", "active after enable drop", active, 0);
    check(cur_frame == 0, "R11", "cur_frame after enable drop", cur_frame, 0);
    pulse_sof();
    wait_cyc(10);
    drain("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule